// File: doc/BRIEF.md
# Audio Sample DMA Channel Pair

This block moves 32-bit audio sample words between system memory and a codec data path. It has two channels. The playback channel reads words from memory and offers them on a playback stream. The capture channel accepts words from a capture stream and writes them to memory. Each word holds one stereo frame of two signed 16-bit samples, so it counts as four bytes.

Software programs each channel through a small word-indexed register port. Each channel has an enable bit, a current byte address and a remaining byte count. A channel moves one word at a time while it is enabled and at least four bytes remain. After each word it advances the address by four and lowers the count by four. When a transfer brings the count to zero, the channel pulses its own completion interrupt. Both channels share one word-wide memory master port, and the bus logic arbitrates between them.

Both sample streams use valid/ready. A word passes on a cycle where valid and ready are both high. The playback side may hold `play_ready` low for as long as it likes. The channel then keeps `play_data` fixed and leaves its registers alone. Capture back-pressure is the reverse: `cap_ready` is low while the channel is disabled, out of bytes, or still writing the previous word. The memory port is a request/acknowledge port. A request holds its address, direction and write data until the cycle in which `mem_ack` is seen. Read data is valid in that same cycle.

Top module: `audio_dma_pair`

## Requirements
- R1: Register indices: 4 is playback control, 5 playback address, 6 playback count; 8 is capture control, 9 capture address, 10 capture count. Control bit 0 is the enable, and the other control bits read as 0. Every other index, including 7, reads 0 and ignores writes. After reset every register reads 0.
- R2: While playback is enabled with a count of at least 4, the channel reads the word at the playback address and presents it on `play_data` with `play_valid` high. On the handshake the address grows by 4 and the count shrinks by 4.
- R3: While capture is enabled with a count of at least 4, `cap_ready` is high. An accepted word is written to the capture address. On the write acknowledge the address grows by 4 and the count shrinks by 4.
- R4: While the playback sink holds `play_ready` low, or no capture word is offered, the address and count stay unchanged and `play_data` stays stable.
- R5: A transfer that takes an enabled channel's count to zero pulses that channel's interrupt (`irq_play_done` or `irq_cap_done`) high for exactly one cycle. The pulse falls in the cycle in which the count first reads 0.
- R6: A channel whose count is below 4 issues no memory request, offers or accepts no word, and raises no interrupt, even when enabled.
- R7: Clearing a channel's enable stops it. A held playback word is withdrawn at once, and the address and count are not updated.
- R8: When a software write to a channel register lands in the same cycle as that channel's transfer update, the written value wins for that register. If the count is overwritten this way, no interrupt is raised.
- R9: On the shared memory port a pending request keeps its address, direction and data until it is acknowledged. When both channels request in the same idle cycle, the playback read goes first.
- R10: A software write to the playback address while a word is held leaves the held word unchanged. The handshake then adds 4 to the written address, and the next fetch uses the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_idx`) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| play_valid | output | 1 | Playback word valid |
| play_ready | input | 1 | Playback sink ready |
| play_data | output | 32 | Playback word (one stereo frame) |
| cap_valid | input | 1 | Capture word valid |
| cap_ready | output | 1 | Capture channel ready |
| cap_data | input | 32 | Capture word (one stereo frame) |
| irq_play_done | output | 1 | Playback completion pulse |
| irq_cap_done | output | 1 | Capture completion pulse |

## Verification
Two functions can fall in the same cycle here. One is a software register write. The other is the update a finished word transfer makes to the same channel's address and count. The bench provokes the collision by raising `play_ready` on a held word in the very cycle it writes the count register. It then reads back the written count, an address advanced by the transfer, and no interrupt. A second collision sets both channels requesting memory in the same idle cycle. The bench judges it from the order of acknowledged transactions seen at the memory port.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
  localparam int WORD_BYTES = 4;
  localparam int REG_IDX_W  = 4;
  localparam int DATA_W     = 32;

  localparam logic [REG_IDX_W-1:0] IDX_PLAY_CTRL = 4'd4;
  localparam logic [REG_IDX_W-1:0] IDX_PLAY_ADDR = 4'd5;
  localparam logic [REG_IDX_W-1:0] IDX_PLAY_CNT  = 4'd6;
  localparam logic [REG_IDX_W-1:0] IDX_CAP_CTRL  = 4'd8;
  localparam logic [REG_IDX_W-1:0] IDX_CAP_ADDR  = 4'd9;
  localparam logic [REG_IDX_W-1:0] IDX_CAP_CNT   = 4'd10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_HOLD = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic              en_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              go,
  output logic              irq_q
);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

  logic step_ok;

  assign go      = en_q && (cnt_q >= CNT_STEP);
  assign step_ok = step && (cnt_q >= CNT_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata[0];
      if (wr_addr)      addr_q <= wdata[ADDR_W-1:0];
      else if (step_ok) addr_q <= addr_q + ADDR_STEP;
      if (wr_cnt)       cnt_q <= wdata[CNT_W-1:0];
      else if (step_ok) cnt_q <= cnt_q - CNT_STEP;
      irq_q <= step_ok && en_q && (cnt_q == CNT_STEP) && !wr_cnt;
    end
  end

  assert_irq_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == '0));
  assert_irq_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(en_q));
  assert_cnt_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/dma_play_chan.sv
module dma_play_chan
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              mreq,
  output logic [ADDR_W-1:0] maddr,
  input  logic              mack,
  input  logic [DATA_W-1:0] mrdata,
  output logic              pvalid,
  input  logic              pready,
  output logic [DATA_W-1:0] pdata,
  output logic              step
);
  xfer_state_e       st_q;
  logic [ADDR_W-1:0] fetch_addr_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      fetch_addr_q <= '0;
      word_q       <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          fetch_addr_q <= addr_q;
          st_q         <= ST_BUS;
        end
        ST_BUS: if (mack) begin
          word_q <= mrdata;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: if (!go || pready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mreq   = (st_q == ST_BUS);
  assign maddr  = fetch_addr_q;
  assign pvalid = (st_q == ST_HOLD) && go;
  assign pdata  = word_q;
  assign step   = pvalid && pready;

  assert_play_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pvalid && !pready) |=> $stable(pdata));
  assert_play_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && !mack) |=> (mreq && $stable(maddr)));
endmodule

// File: rtl/dma_cap_chan.sv
module dma_cap_chan
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              mreq,
  output logic [ADDR_W-1:0] maddr,
  output logic [DATA_W-1:0] mwdata,
  input  logic              mack,
  input  logic              cvalid,
  output logic              cready,
  input  logic [DATA_W-1:0] cdata,
  output logic              step
);
  xfer_state_e       st_q;
  logic [ADDR_W-1:0] store_addr_q;
  logic [DATA_W-1:0] word_q;

  assign cready = (st_q == ST_IDLE) && go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      store_addr_q <= '0;
      word_q       <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cvalid && cready) begin
          word_q       <= cdata;
          store_addr_q <= addr_q;
          st_q         <= ST_BUS;
        end
        ST_BUS: if (mack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mreq   = (st_q == ST_BUS);
  assign maddr  = store_addr_q;
  assign mwdata = word_q;
  assign step   = mreq && mack;

  assert_cap_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && !mack) |=> (mreq && $stable(maddr) && $stable(mwdata)));
  assert_cap_no_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mreq |-> !cready);
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_req,
  input  logic [ADDR_W-1:0] p_addr,
  output logic              p_ack,
  input  logic              c_req,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic              c_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack
);
  logic busy_q;
  logic owner_cap_q;
  logic sel_cap;

  assign sel_cap   = busy_q ? owner_cap_q : (c_req && !p_req);
  assign mem_req   = sel_cap ? c_req : p_req;
  assign mem_we    = sel_cap;
  assign mem_addr  = sel_cap ? c_addr : p_addr;
  assign mem_wdata = c_wdata;
  assign p_ack     = mem_ack && !sel_cap;
  assign c_ack     = mem_ack && sel_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      owner_cap_q <= 1'b0;
    end else begin
      busy_q      <= mem_req && !mem_ack;
      owner_cap_q <= sel_cap;
    end
  end

  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
  assert_tie_play_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && c_req && !busy_q) |-> (mem_req && !mem_we));
endmodule

// File: rtl/audio_dma_pair.sv
module audio_dma_pair
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              play_valid,
  input  logic              play_ready,
  output logic [31:0]       play_data,
  input  logic              cap_valid,
  output logic              cap_ready,
  input  logic [31:0]       cap_data,
  output logic              irq_play_done,
  output logic              irq_cap_done
);
  localparam int NCH = 2;

  logic              en_q   [NCH];
  logic [ADDR_W-1:0] addr_q [NCH];
  logic [CNT_W-1:0]  cnt_q  [NCH];
  logic              go     [NCH];
  logic              irq_q  [NCH];
  logic              step   [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_regs
    localparam logic [REG_IDX_W-1:0] CTRL_IDX = (g == 0) ? IDX_PLAY_CTRL : IDX_CAP_CTRL;
    localparam logic [REG_IDX_W-1:0] ADDR_IDX = (g == 0) ? IDX_PLAY_ADDR : IDX_CAP_ADDR;
    localparam logic [REG_IDX_W-1:0] CNT_IDX  = (g == 0) ? IDX_PLAY_CNT  : IDX_CAP_CNT;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (reg_we && (reg_idx == CTRL_IDX)),
      .wr_addr (reg_we && (reg_idx == ADDR_IDX)),
      .wr_cnt  (reg_we && (reg_idx == CNT_IDX)),
      .wdata   (reg_wdata),
      .step    (step[g]),
      .en_q    (en_q[g]),
      .addr_q  (addr_q[g]),
      .cnt_q   (cnt_q[g]),
      .go      (go[g]),
      .irq_q   (irq_q[g])
    );
  end

  logic              p_req, p_ack, c_req, c_ack;
  logic [ADDR_W-1:0] p_addr, c_addr;
  logic [31:0]       c_wdata;

  dma_play_chan #(.ADDR_W(ADDR_W)) u_play (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go[0]),
    .addr_q (addr_q[0]),
    .mreq   (p_req),
    .maddr  (p_addr),
    .mack   (p_ack),
    .mrdata (mem_rdata),
    .pvalid (play_valid),
    .pready (play_ready),
    .pdata  (play_data),
    .step   (step[0])
  );

  dma_cap_chan #(.ADDR_W(ADDR_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go[1]),
    .addr_q (addr_q[1]),
    .mreq   (c_req),
    .maddr  (c_addr),
    .mwdata (c_wdata),
    .mack   (c_ack),
    .cvalid (cap_valid),
    .cready (cap_ready),
    .cdata  (cap_data),
    .step   (step[1])
  );

  dma_bus_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .p_req     (p_req),
    .p_addr    (p_addr),
    .p_ack     (p_ack),
    .c_req     (c_req),
    .c_addr    (c_addr),
    .c_wdata   (c_wdata),
    .c_ack     (c_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
  );

  always_comb begin
    case (reg_idx)
      IDX_PLAY_CTRL: reg_rdata = {31'b0, en_q[0]};
      IDX_PLAY_ADDR: reg_rdata = 32'(addr_q[0]);
      IDX_PLAY_CNT:  reg_rdata = 32'(cnt_q[0]);
      IDX_CAP_CTRL:  reg_rdata = {31'b0, en_q[1]};
      IDX_CAP_ADDR:  reg_rdata = 32'(addr_q[1]);
      IDX_CAP_CNT:   reg_rdata = 32'(cnt_q[1]);
      default:       reg_rdata = 32'b0;
    endcase
  end

  assign irq_play_done = irq_q[0];
  assign irq_cap_done  = irq_q[1];

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_play_done |=> !irq_play_done);
  assert_idle_no_play_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !go[0] |-> !play_valid);
endmodule

// File: tb/audio_dma_pair_tb_top.sv
`timescale 1ns/1ps
module audio_dma_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        play_valid;
  logic        play_ready = 1'b0;
  logic [31:0] play_data;
  logic        cap_valid = 1'b0;
  logic        cap_ready;
  logic [31:0] cap_data = '0;
  logic        irq_play_done, irq_cap_done;

  always #2.5 clk = ~clk;

  audio_dma_pair dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .play_valid(play_valid),
    .play_ready(play_ready), .play_data(play_data), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_data(cap_data),
    .irq_play_done(irq_play_done), .irq_cap_done(irq_cap_done)
  );

  // memory model and monitors
  logic [31:0] mem [64];
  logic        log_we [64];
  logic [31:0] log_addr [64];
  int xact_n, req_cycles, play_irqs, cap_irqs;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      xact_n <= 0; req_cycles <= 0; play_irqs <= 0; cap_irqs <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= 32'hA000_0000 + 32'(i);
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mem_rdata <= mem[mem_addr[7:2]];
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      end else mem_ack <= 1'b0;
      if (mem_req) req_cycles <= req_cycles + 1;
      if (mem_req && mem_ack) begin
        log_we[xact_n[5:0]] <= mem_we;
        log_addr[xact_n[5:0]] <= mem_addr;
        xact_n <= xact_n + 1;
      end
      if (irq_play_done) play_irqs <= play_irqs + 1;
      if (irq_cap_done) cap_irqs <= cap_irqs + 1;
    end
  end

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] idx, output logic [31:0] val);
    @(negedge clk);
    reg_idx = idx;
    #1 val = reg_rdata;
  endtask

  task automatic expect_reg(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    reg_read(idx, v);
    check(v === exp, tag, v, exp);
  endtask

  task automatic wait_valid(input string tag);
    for (int i = 0; i < 50 && !play_valid; i++) @(negedge clk);
    check(play_valid === 1'b1, tag, 32'(play_valid), 32'd1);
  endtask

  task automatic take_word(input logic [31:0] exp, input bit bp, input string tag);
    @(negedge clk);
    if (bp) begin
      play_ready = 1'b0;
      repeat (3) @(negedge clk);
    end
    play_ready = 1'b1;
    wait_valid(tag);
    check(play_data === exp, tag, play_data, exp);
    @(posedge clk);
    @(negedge clk);
    play_ready = 1'b0;
  endtask

  task automatic give_word(input logic [31:0] val, input string tag);
    @(negedge clk);
    cap_valid = 1'b1; cap_data = val;
    for (int i = 0; i < 50 && !cap_ready; i++) @(negedge clk);
    check(cap_ready === 1'b1, tag, 32'(cap_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  // vector: {dir(1=capture), backpressure, base address, byte count}
  localparam int NV = 5;
  localparam logic [65:0] VECS [NV] = '{
    {1'b0, 1'b0, 32'h0000_0000, 32'd4},
    {1'b0, 1'b1, 32'h0000_0020, 32'd16},
    {1'b1, 1'b0, 32'h0000_0080, 32'd8},
    {1'b1, 1'b0, 32'h0000_00C0, 32'd12},
    {1'b0, 1'b1, 32'h0000_0040, 32'd12}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int n0, i0, r0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 16; k++) expect_reg(4'(k), 32'd0, "R1 reset value");
    check(!mem_req && !play_valid && !irq_play_done && !irq_cap_done, "R1 reset outputs", 32'(mem_req), 0);

    // R1 reserved words ignore writes; control keeps bit 0 only
    reg_write(4'd7, 32'hFFFF_FFFF);
    expect_reg(4'd7, 32'd0, "R1 word 7 reserved");
    reg_write(4'd0, 32'hFFFF_FFFF);
    expect_reg(4'd0, 32'd0, "R1 word 0 ignored");
    reg_write(4'd9, 32'h0000_1234);
    expect_reg(4'd9, 32'h0000_1234, "R1 capture address");
    reg_write(4'd8, 32'hFFFF_FFFE);
    expect_reg(4'd8, 32'd0, "R1 ctrl bit 0 only");

    // table walk: R2 R3 R5
    for (int n = 0; n < NV; n++) begin
      logic dir, bp;
      logic [31:0] base, bytes;
      {dir, bp, base, bytes} = VECS[n];
      i0 = dir ? cap_irqs : play_irqs;
      reg_write(dir ? 4'd9 : 4'd5, base);
      reg_write(dir ? 4'd10 : 4'd6, bytes);
      reg_write(dir ? 4'd8 : 4'd4, 32'd1);
      for (int w = 0; w < int'(bytes) / 4; w++) begin
        if (dir) give_word(32'hC000_0000 + 32'(w), "R3 capture accept");
        else take_word(32'hA000_0000 + (base >> 2) + 32'(w), bp, "R2 playback data");
      end
      repeat (10) @(negedge clk);
      if (dir)
        for (int w = 0; w < int'(bytes) / 4; w++) begin
          v = mem[6'((base >> 2) + 32'(w))];
          check(v === 32'hC000_0000 + 32'(w), "R3 memory written", v, 32'hC000_0000 + 32'(w));
        end
      expect_reg(dir ? 4'd9 : 4'd5, base + bytes, dir ? "R3 final address" : "R2 final address");
      expect_reg(dir ? 4'd10 : 4'd6, 32'd0, dir ? "R3 final count" : "R2 final count");
      v = 32'((dir ? cap_irqs : play_irqs) - i0);
      check(v === 32'd1, "R5 one completion pulse", v, 32'd1);
      reg_write(dir ? 4'd8 : 4'd4, 32'd0);
    end

    // R6 short count: no requests, nothing offered, no irq
    r0 = req_cycles; i0 = play_irqs;
    reg_write(4'd5, 32'h0); reg_write(4'd6, 32'd2); reg_write(4'd4, 32'd1);
    @(negedge clk) play_ready = 1'b1;
    repeat (20) @(negedge clk);
    check(req_cycles == r0, "R6 no memory request", 32'(req_cycles - r0), 0);
    check(!play_valid, "R6 nothing offered", 32'(play_valid), 0);
    check(play_irqs == i0, "R6 no irq", 32'(play_irqs - i0), 0);
    play_ready = 1'b0;
    reg_write(4'd4, 32'd0);

    // R4 stall under back-pressure
    reg_write(4'd5, 32'h10); reg_write(4'd6, 32'd8); reg_write(4'd4, 32'd1);
    wait_valid("R4 word held");
    v = play_data;
    repeat (20) @(negedge clk);
    check(play_data === v && v === 32'hA000_0004, "R4 data stable", play_data, 32'hA000_0004);
    expect_reg(4'd5, 32'h10, "R4 address unchanged");
    expect_reg(4'd6, 32'd8, "R4 count unchanged");
    // R7 disable withdraws the word without update
    reg_write(4'd4, 32'd0);
    check(!play_valid, "R7 word withdrawn", 32'(play_valid), 0);
    expect_reg(4'd5, 32'h10, "R7 address kept");
    expect_reg(4'd6, 32'd8, "R7 count kept");

    // R8 collision: count write and handshake in the same cycle
    reg_write(4'd5, 32'h0); reg_write(4'd6, 32'd8); reg_write(4'd4, 32'd1);
    wait_valid("R8 word held");
    @(negedge clk);
    play_ready = 1'b1; reg_we = 1'b1; reg_idx = 4'd6; reg_wdata = 32'd100;
    @(posedge clk);
    @(negedge clk);
    play_ready = 1'b0; reg_we = 1'b0;
    expect_reg(4'd6, 32'd100, "R8 written count wins");
    expect_reg(4'd5, 32'd4, "R8 address still advanced");
    reg_write(4'd4, 32'd0);
    // R8 irq suppressed when the final count is overwritten
    i0 = play_irqs;
    reg_write(4'd5, 32'h0); reg_write(4'd6, 32'd4); reg_write(4'd4, 32'd1);
    wait_valid("R8 last word held");
    @(negedge clk);
    play_ready = 1'b1; reg_we = 1'b1; reg_idx = 4'd6; reg_wdata = 32'd40;
    @(posedge clk);
    @(negedge clk);
    play_ready = 1'b0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    expect_reg(4'd6, 32'd40, "R8 count overwritten");
    check(play_irqs == i0, "R8 no irq on overwrite", 32'(play_irqs - i0), 0);
    reg_write(4'd4, 32'd0);

    // R10 address rewrite while a word is held
    i0 = play_irqs;
    reg_write(4'd5, 32'h0); reg_write(4'd6, 32'd8); reg_write(4'd4, 32'd1);
    wait_valid("R10 first word held");
    reg_write(4'd5, 32'h40);
    check(play_data === 32'hA000_0000, "R10 held word unchanged", play_data, 32'hA000_0000);
    take_word(32'hA000_0000, 1'b0, "R10 first word");
    expect_reg(4'd5, 32'h44, "R10 address from written value");
    take_word(32'hA000_0011, 1'b0, "R10 next fetch uses new address");
    repeat (3) @(negedge clk);
    check(play_irqs - i0 == 1, "R5 irq after rewrite", 32'(play_irqs - i0), 1);
    reg_write(4'd4, 32'd0);

    // R9 tie on the memory port: playback read first
    reg_write(4'd5, 32'h08); reg_write(4'd6, 32'd4);
    reg_write(4'd9, 32'hF0); reg_write(4'd10, 32'd4); reg_write(4'd8, 32'd1);
    n0 = xact_n;
    reg_write(4'd4, 32'd1);
    cap_valid = 1'b1; cap_data = 32'h5555_AAAA;
    @(posedge clk);
    @(negedge clk);
    cap_valid = 1'b0;
    play_ready = 1'b1;
    repeat (10) @(negedge clk);
    play_ready = 1'b0;
    check(xact_n - n0 == 2, "R9 two transactions", 32'(xact_n - n0), 2);
    check(log_we[n0[5:0]] === 1'b0 && log_addr[n0[5:0]] === 32'h08, "R9 playback first",
          log_addr[n0[5:0]], 32'h08);
    check(log_we[6'(n0 + 1)] === 1'b1 && log_addr[6'(n0 + 1)] === 32'hF0, "R9 capture second",
          log_addr[6'(n0 + 1)], 32'hF0);
    check(mem[60] === 32'h5555_AAAA, "R3 tie write data", mem[60], 32'h5555_AAAA);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule